// File: doc/BRIEF.md
# Register Readback Controller

This block sits behind a serial frame receiver. It owns a small register file of 14-bit values, indexed by a 4-bit channel number and a 2-bit register type (16 × 4 entries). Each 24-bit word delivered by the receiver either writes one entry or asks for one entry to be read back. A read does not answer in the frame that carried it. Its response is shifted out on the serial data output during the following framed transfer, most significant bit first.

The response word keeps the request's upper 10 bits (the header) in its top bits and places the selected 14-bit register value in its low bits. The receiver supplies three single-cycle pulses in the system clock domain: a frame start (select going active), a shift strobe (one per serial clock rising edge) and a word-valid at the end of a complete frame. An all-zero word is a no-operation and is normally used as the second frame of a readback.

Top module: `readback_regs`

## Requirements
- R1: After reset, sdo is 0, every register entry holds 0, and no readback is pending.
- R2: A word with bit 22 clear that is not all zeros, accepted with wordValid, writes bits 13:0 into the entry chosen by channel bits 21:18 and type bits 15:14.
- R3: The all-zero word writes no entry.
- R4: A word with bit 22 set writes no entry, whatever its bits 13:0 hold.
- R5: In the frame after a read request, sdo carries {request bits 23:14, selected entry} MSB first. The MSB appears in the cycle after frameStart, and each shiftStrobe moves sdo to the next lower bit. Without a frameStart or shiftStrobe, sdo holds its value.
- R6: The frame in which a read request is received does not carry that request's response. It carries whatever the previous word asked for.
- R7: If the last accepted word was not a read request (a write or a NOP), or no word has been accepted since reset, sdo is 0 for the whole next frame.
- R8: A frameStart consumes a pending response. If that frame ends without wordValid, the frame after it outputs zeros.
- R9: Once 24 bits have been shifted in a frame, sdo stays 0 until the next frameStart.
- R10: Bits 23, 17 and 16 do not take part in selecting the entry. Bits 17:16 of a read request are echoed in the response header.
- R11: The request word 0x404000 reads type 1 of channel 0. With that entry holding 0x2222, the response is 0x406222.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | One-cycle pulse at the start of a framed transfer |
| shiftStrobe | input | 1 | One-cycle pulse per serial clock rising edge; advances sdo |
| wordValid | input | 1 | One-cycle pulse: wordIn holds a complete received word |
| wordIn | input | 24 | Received word: bit 22 read, 21:18 channel, 15:14 type, 13:0 data |
| sdo | output | 1 | Serial response bit |

## Verification
The bench targets the one-frame delay, which breaks in two ways. A design that answers in the request frame would show data where zeros belong. A design that never clears its pending flag would repeat an old response after a write, a NOP or an aborted frame. Field decoding is exercised by writing every channel with a distinct value and by setting the unused bits 17:16, so swapped or overlapping address and type slices return the wrong entry. The no-write rules for the all-zero word and for read requests carrying junk data are checked by reading the entries back afterwards. A design that wrote anyway would return the junk or a cleared value. The bench also checks that sdo returns to zero after the 24th shift, which catches a shift register that recirculates bits instead of filling with zeros.

// File: rtl/readback_pkg.sv
package readback_pkg;

  // strobes from control to datapath, all single-cycle
  typedef struct packed {
    logic wrEn;      // write the addressed register entry
    logic capResp;   // latch header plus selected entry as the response
    logic loadResp;  // start of frame, response pending: load shifter
    logic loadZero;  // start of frame, nothing pending: clear shifter
    logic shift;     // advance shifter by one bit
  } rbStrobes_t;

endpackage

// File: rtl/readback_ctrl.sv
module readback_ctrl
  import readback_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int RW_BIT = 22
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStart,
  input  logic              shiftStrobe,
  input  logic              wordValid,
  input  logic [WORD_W-1:0] wordIn,
  output rbStrobes_t        strobes
);

  logic isRead;
  logic isNop;
  logic pending;

  assign isRead = wordIn[RW_BIT];
  assign isNop  = (wordIn == '0);

  always_comb begin
    strobes.wrEn     = wordValid && !isRead && !isNop;
    strobes.capResp  = wordValid && isRead;
    strobes.loadResp = frameStart && pending;
    strobes.loadZero = frameStart && !pending;
    strobes.shift    = shiftStrobe && !frameStart;
  end

  // pending follows the last accepted word; a frame start consumes it
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= 1'b0;
    end else if (wordValid) begin
      pending <= isRead;
    end else if (frameStart) begin
      pending <= 1'b0;
    end
  end

endmodule

// File: rtl/readback_datapath.sv
module readback_datapath
  import readback_pkg::*;
#(
  parameter int WORD_W   = 24,
  parameter int ADDR_W   = 4,
  parameter int TYPE_W   = 2,
  parameter int DATA_W   = 14,
  parameter int ADDR_LSB = 18,
  parameter int TYPE_LSB = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  rbStrobes_t        strobes,
  input  logic [WORD_W-1:0] wordIn,
  output logic              sdo
);

  localparam int SEL_W   = ADDR_W + TYPE_W;
  localparam int NUM_ENT = 1 << SEL_W;
  localparam int HDR_W   = WORD_W - DATA_W;

  logic [DATA_W-1:0] regFile [NUM_ENT];
  logic [SEL_W-1:0]  sel;
  logic [WORD_W-1:0] respReg;
  logic [WORD_W-1:0] shiftReg;

  assign sel = {wordIn[ADDR_LSB +: ADDR_W], wordIn[TYPE_LSB +: TYPE_W]};

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        regFile[e] <= '0;
      end else if (strobes.wrEn && (sel == SEL_W'(e))) begin
        regFile[e] <= wordIn[DATA_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respReg <= '0;
    end else if (strobes.capResp) begin
      respReg <= {wordIn[WORD_W-1 -: HDR_W], regFile[sel]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobes.loadResp) begin
      shiftReg <= respReg;
    end else if (strobes.loadZero) begin
      shiftReg <= '0;
    end else if (strobes.shift) begin
      shiftReg <= {shiftReg[WORD_W-2:0], 1'b0};
    end
  end

  assign sdo = shiftReg[WORD_W-1];

endmodule

// File: rtl/readback_regs.sv
module readback_regs
  import readback_pkg::*;
#(
  parameter int WORD_W   = 24,
  parameter int ADDR_W   = 4,
  parameter int TYPE_W   = 2,
  parameter int DATA_W   = 14,
  parameter int RW_BIT   = 22,
  parameter int ADDR_LSB = 18,
  parameter int TYPE_LSB = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStart,
  input  logic              shiftStrobe,
  input  logic              wordValid,
  input  logic [WORD_W-1:0] wordIn,
  output logic              sdo
);

  rbStrobes_t strobes;

  readback_ctrl #(
    .WORD_W(WORD_W),
    .RW_BIT(RW_BIT)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameStart (frameStart),
    .shiftStrobe(shiftStrobe),
    .wordValid  (wordValid),
    .wordIn     (wordIn),
    .strobes    (strobes)
  );

  readback_datapath #(
    .WORD_W  (WORD_W),
    .ADDR_W  (ADDR_W),
    .TYPE_W  (TYPE_W),
    .DATA_W  (DATA_W),
    .ADDR_LSB(ADDR_LSB),
    .TYPE_LSB(TYPE_LSB)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .wordIn (wordIn),
    .sdo    (sdo)
  );

endmodule

// File: rtl/readback_regs_chk.sv
module readback_regs_chk
  import readback_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int RW_BIT = 22
) (
  input logic              clk,
  input logic              rstN,
  input logic              frameStart,
  input logic              shiftStrobe,
  input logic              wordValid,
  input logic [WORD_W-1:0] wordIn,
  input logic              sdo,
  input rbStrobes_t        strobes
);

  localparam int CNT_W = $clog2(WORD_W + 1);

  logic [CNT_W-1:0] shiftCnt;
  logic             pendModel;
  logic             hdrMsb;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftCnt  <= CNT_W'(WORD_W);
      pendModel <= 1'b0;
      hdrMsb    <= 1'b0;
    end else begin
      if (frameStart) begin
        shiftCnt <= '0;
      end else if (shiftStrobe && shiftCnt != CNT_W'(WORD_W)) begin
        shiftCnt <= shiftCnt + 1'b1;
      end
      if (wordValid) begin
        pendModel <= wordIn[RW_BIT];
        if (wordIn[RW_BIT]) hdrMsb <= wordIn[WORD_W-1];
      end else if (frameStart) begin
        pendModel <= 1'b0;
      end
    end
  end

  // R5
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!frameStart && !shiftStrobe) |=> $stable(sdo));

  // R5
  resp_msb_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && pendModel) |=> (sdo == hdrMsb));

  // R7
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && !pendModel) |=> (sdo == 1'b0));

  // R9
  drained_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (shiftCnt == CNT_W'(WORD_W)) |-> (sdo == 1'b0));

  // R3
  nop_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && wordIn == '0) |-> !strobes.wrEn);

  // R4
  read_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wordIn[RW_BIT]) |-> !strobes.wrEn);

endmodule

bind readback_regs readback_regs_chk #(
  .WORD_W(WORD_W),
  .RW_BIT(RW_BIT)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .frameStart (frameStart),
  .shiftStrobe(shiftStrobe),
  .wordValid  (wordValid),
  .wordIn     (wordIn),
  .sdo        (sdo),
  .strobes    (strobes)
);

// File: tb/readback_regs_bench.sv
`timescale 1ns/1ps
module readback_regs_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameStart = 1'b0;
  logic        shiftStrobe = 1'b0;
  logic        wordValid = 1'b0;
  logic [23:0] wordIn = '0;
  logic        sdo;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  readback_regs u_readback_regs (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .shiftStrobe(shiftStrobe),
    .wordValid(wordValid), .wordIn(wordIn), .sdo(sdo)
  );

  function automatic logic [23:0] mkWrite(input int ch, input int typ, input logic [13:0] d);
    return {1'b0, 1'b0, 4'(ch), 2'b00, 2'(typ), d};
  endfunction

  function automatic logic [23:0] mkRead(input int ch, input int typ, input logic [13:0] junk);
    return {1'b0, 1'b1, 4'(ch), 2'b00, 2'(typ), junk};
  endfunction

  function automatic logic [23:0] resp(input logic [23:0] req, input logic [13:0] d);
    return {req[23:14], d};
  endfunction

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%06h expected 0x%06h", tag, act, exp);
    end
  endtask

  // one framed transfer: collect 24 response bits, then deliver a word
  task automatic runFrame(input logic [23:0] word, output logic [23:0] got, input bit deliver = 1'b1);
    @(negedge clk) frameStart = 1'b1;
    @(negedge clk) frameStart = 1'b0;
    for (int i = 0; i < 24; i++) begin
      got[23-i] = sdo;
      shiftStrobe = 1'b1;
      @(negedge clk);
    end
    shiftStrobe = 1'b0;
    check("R9 sdo after 24 shifts", {23'd0, sdo}, 24'd0);
    if (deliver) begin
      wordIn = word;
      wordValid = 1'b1;
      @(negedge clk);
      wordValid = 1'b0;
      wordIn = '0;
    end
  endtask

  task automatic testReset();
    logic [23:0] got;
    logic [23:0] rd;
    check("R1 sdo at reset", {23'd0, sdo}, 24'd0);
    runFrame(24'h0, got);
    check("R1/R7 first frame after reset", got, 24'd0);
    rd = mkRead(7, 2, 14'h155);
    runFrame(rd, got);
    check("R7 frame after NOP", got, 24'd0);
    runFrame(24'h0, got);
    check("R1 entry zero after reset", got, resp(rd, 14'h0));
  endtask

  task automatic testWriteRead();
    logic [23:0] got;
    logic [23:0] rd;
    rd = mkRead(3, 1, 14'h3FFF);
    runFrame(mkWrite(3, 1, 14'h1234), got);
    runFrame(rd, got);
    check("R6 request frame carries no response", got, 24'd0);
    runFrame(24'h0, got);
    check("R2/R5 readback of written entry", got, resp(rd, 14'h1234));
  endtask

  task automatic testNop();
    logic [23:0] got;
    logic [23:0] rd;
    rd = mkRead(0, 0, 14'h0);
    runFrame(mkWrite(0, 0, 14'h0ABC), got);
    runFrame(24'h0, got);
    runFrame(24'h0, got);
    runFrame(rd, got);
    runFrame(24'h0, got);
    check("R3 NOP leaves ch0 type0 intact", got, resp(rd, 14'h0ABC));
  endtask

  task automatic testExample();
    logic [23:0] got;
    runFrame(mkWrite(0, 1, 14'h2222), got);
    runFrame(24'h404000, got);
    runFrame(24'h0, got);
    check("R11 0x404000 readback", got, 24'h406222);
  endtask

  task automatic testReadNoWrite();
    logic [23:0] got;
    logic [23:0] rdA;
    logic [23:0] rdB;
    rdA = mkRead(3, 1, 14'h0F0F);
    rdB = mkRead(3, 1, 14'h0000);
    runFrame(rdA, got);
    runFrame(rdB, got);
    check("R4 first read of entry", got, resp(rdA, 14'h1234));
    runFrame(24'h0, got);
    check("R4 read junk did not write", got, resp(rdB, 14'h1234));
  endtask

  task automatic testBackToBack();
    logic [23:0] got;
    logic [23:0] rdA;
    logic [23:0] rdB;
    rdA = mkRead(9, 2, 14'h0);
    rdB = mkRead(10, 3, 14'h0);
    runFrame(mkWrite(9, 2, 14'h0111), got);
    runFrame(mkWrite(10, 3, 14'h3FFF), got);
    runFrame(rdA, got);
    runFrame(rdB, got);
    check("R6 back-to-back first response", got, resp(rdA, 14'h0111));
    runFrame(24'h0, got);
    check("R6 back-to-back second response", got, resp(rdB, 14'h3FFF));
    runFrame(24'h0, got);
    check("R7 response not repeated", got, 24'd0);
  endtask

  task automatic testWriteClears();
    logic [23:0] got;
    logic [23:0] rd;
    rd = mkRead(9, 2, 14'h0);
    runFrame(rd, got);
    runFrame(mkWrite(1, 1, 14'h0042), got);
    check("R5 response during write frame", got, resp(rd, 14'h0111));
    runFrame(24'h0, got);
    check("R7 write clears pending", got, 24'd0);
  endtask

  task automatic testBadFrame();
    logic [23:0] got;
    logic [23:0] rd;
    rd = mkRead(10, 3, 14'h0);
    runFrame(rd, got);
    runFrame(24'h0, got, 1'b0);
    check("R8 aborted frame still carried response", got, resp(rd, 14'h3FFF));
    runFrame(24'h0, got);
    check("R8 frame after aborted frame", got, 24'd0);
  endtask

  task automatic testIgnoredBits();
    logic [23:0] got;
    logic [23:0] wr;
    logic [23:0] rd;
    wr = mkWrite(5, 2, 14'h0C3C);
    wr[17:16] = 2'b11;
    rd = mkRead(5, 2, 14'h0);
    rd[17:16] = 2'b10;
    rd[23] = 1'b1;
    runFrame(wr, got);
    runFrame(rd, got);
    runFrame(24'h0, got);
    check("R10 unused bits ignored and echoed", got, resp(rd, 14'h0C3C));
  endtask

  task automatic testAllChannels();
    logic [23:0] got;
    logic [23:0] prev;
    for (int ch = 0; ch < 16; ch++) begin
      runFrame(mkWrite(ch, 3, 14'(ch * 14'h111 + 1)), got);
    end
    prev = '0;
    for (int ch = 0; ch < 16; ch++) begin
      runFrame(mkRead(ch, 3, 14'h0), got);
      if (ch > 0) check("R2 channel decode", got, resp(prev, 14'((ch - 1) * 14'h111 + 1)));
      prev = mkRead(ch, 3, 14'h0);
    end
    runFrame(24'h0, got);
    check("R2 last channel", got, resp(prev, 14'(15 * 14'h111 + 1)));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testWriteRead();
    testNop();
    testExample();
    testReadNoWrite();
    testBackToBack();
    testWriteClears();
    testBadFrame();
    testIgnoredBits();
    testAllChannels();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule